// File: doc/BRIEF.md
# Lockstep SIMD Array Sequencer with Per-Lane Masking

This block sequences a row of identical processing lanes from one instruction stream. Each cycle it looks at the instruction word at its program counter. Scalar instructions run in the sequencer itself: branch, halt, set-all and lane read. Array instructions go out to every lane in the same cycle. No lane fetches or orders instructions by itself. Each lane has a small register file, a simple ALU and an activity flag. A lane whose flag is clear ignores array instructions.

For global decisions the sequencer uses two registered reduction lines across the lanes. The any line is the OR of every lane's compare bit, and the all line is the AND. When the mask-to-active input is high, inactive lanes drop out of both lines. The sequencer can also copy one register of a selected lane into its scalar result register.

The sequencer is a three-state machine:
- `ST_IDLE` is the state after reset. It moves to `ST_RUN` at `start_i`, with the program counter at 0.
- `ST_RUN` runs one instruction per cycle. A halt instruction moves it to `ST_HALT`.
- `ST_HALT` moves back to `ST_RUN` at `start_i`, with the program counter at 0.

The instruction source sits outside the block and returns the word at `pc_o` in the same cycle.

Top module: `simd_array_ctl`

## Requirements
- R1: After reset the sequencer is in `ST_IDLE`:
  - `pc_o`, `scalar_o`, `any_o` and `all_o` are 0, and `busy_o` and `halted_o` are low.
  - Every lane flag is 1 and every lane register is 0.
- R2: In `ST_IDLE`, `start_i` enters `ST_RUN` with `pc_o`=0. Each instruction other than branch or halt advances `pc_o` by one.
- R3: The instruction word is laid out as follows: bits [15:12] opcode, [11] flag-update, [10:9] rd, [8:7] rs1, [6:5] rs2, [4:0] imm. An array opcode (bit 15 set) runs in every active lane in the same cycle:
  - 8 ADD: rd=rs1+rs2
  - 9 SUB: rd=rs1-rs2
  - 10 AND: rd=rs1&rs2
  - 11 XOR: rd=rs1^rs2
  - 12 LDI: rd=imm, zero-extended
  - 13 LID: rd=lane index
- R4: A lane whose flag is 0 leaves its registers, compare bit and flag unchanged for every array opcode.
- R5: The compare opcodes are 14 (rs1<rs2, unsigned) and 15 (rs1==rs2). An active lane stores the result bit as its compare bit and writes it to rd as 0 or 1. If the flag-update bit is set, the result is also written into the lane's flag.
- R6: Opcode 4 (set-all) sets every lane's flag to 1, whatever its previous value.
- R7: With `red_mask_i` low:
  - `any_o` is the OR of all lane compare bits, and `all_o` is the AND.
  - Both are registered, so a compare executed at one clock edge shows on them after the next edge.
- R8: With `red_mask_i` high, only active lanes count. `any_o`=OR(cmp&flag) and `all_o`=AND(cmp|~flag), so `all_o` is 1 when no lane is active.
- R9: Opcode 2 branches to imm. rd[0] selects the condition: 0 tests the current `any_o`, 1 tests the current `all_o`. rd[1] is the polarity: the branch is taken when the tested value equals rd[1]. When it is not taken, `pc_o` advances by one.
- R10: Opcode 3 loads register rs1 of the lane numbered by imm[2:0] into `scalar_o` at the next edge, whether that lane is active or not.
- R11: Opcode 1 enters `ST_HALT`:
  - `pc_o` holds, `halted_o` is high, and instructions are ignored.
  - `start_i` restarts the sequencer in `ST_RUN` at `pc_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Leave `ST_IDLE` or `ST_HALT` and run from address 0 |
| instr_i | input | 16 | Instruction word at `pc_o` |
| red_mask_i | input | 1 | Exclude inactive lanes from the reduction lines |
| pc_o | output | PC_W (5) | Program counter |
| busy_o | output | 1 | Sequencer is in `ST_RUN` |
| halted_o | output | 1 | Sequencer is in `ST_HALT` |
| scalar_o | output | W (8) | Scalar result from the last lane read |
| flags_o | output | N (8) | Lane activity flags, bit i for lane i |
| any_o | output | 1 | Registered OR reduction |
| all_o | output | 1 | Registered AND reduction |

## Verification
The checker watches the sequencer on every cycle:
- the program counter: it holds in idle and halt, starts at zero, steps by one, and jumps on a taken branch;
- the set-all effect and the halt entry;
- that no cleared flag comes back without a set-all;
- that an unmasked all-line never stands without the any-line.

Only the bench scenarios can show what happens to lane data: arithmetic results, registers left untouched in masked-off lanes, compare results written to rd and flags, and lane read-back. They also cover the one-cycle lag of the reduction lines and the masked all-line with every lane inactive.

// File: rtl/simd_pkg.sv
package simd_pkg;
    localparam int INSTR_W = 16;
    localparam int NREG    = 4;
    localparam int RIDX_W  = 2;
    localparam int IMM_W   = 5;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_HALT   = 4'd1,
        OP_BR     = 4'd2,
        OP_RDPE   = 4'd3,
        OP_SETALL = 4'd4,
        OP_ADD    = 4'd8,
        OP_SUB    = 4'd9,
        OP_AND    = 4'd10,
        OP_XOR    = 4'd11,
        OP_LDI    = 4'd12,
        OP_LID    = 4'd13,
        OP_CLT    = 4'd14,
        OP_CEQ    = 4'd15
    } opcode_e;

    typedef struct packed {
        logic [3:0]        op;
        logic              fupd;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rs1;
        logic [RIDX_W-1:0] rs2;
        logic [IMM_W-1:0]  imm;
    } instr_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/simd_pe.sv
module simd_pe
    import simd_pkg::*;
#(
    parameter int W    = 8,
    parameter int LANE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [3:0]        op_i,
    input  logic              fupd_i,
    input  logic [RIDX_W-1:0] rd_i,
    input  logic [RIDX_W-1:0] rs1_i,
    input  logic [RIDX_W-1:0] rs2_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              setall_i,
    output logic              flag_o,
    output logic              cmp_o,
    output logic [W-1:0]      rdval_o
);
    logic [W-1:0] rf_q [NREG];
    logic         flag_q;
    logic         cmp_q;
    logic [W-1:0] a, b, res;
    logic         wr_en, is_cmp, cbit, exec;

    assign a       = rf_q[rs1_i];
    assign b       = rf_q[rs2_i];
    assign exec    = issue_i && flag_q;
    assign flag_o  = flag_q;
    assign cmp_o   = cmp_q;
    assign rdval_o = a;

    always_comb begin
        res    = '0;
        wr_en  = 1'b1;
        is_cmp = 1'b0;
        cbit   = 1'b0;
        case (op_i)
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_AND:  res = a & b;
            OP_XOR:  res = a ^ b;
            OP_LDI:  res = W'(imm_i);
            OP_LID:  res = W'(LANE);
            OP_CLT: begin
                is_cmp = 1'b1;
                cbit   = (a < b);
                res    = {{(W-1){1'b0}}, cbit};
            end
            OP_CEQ: begin
                is_cmp = 1'b1;
                cbit   = (a == b);
                res    = {{(W-1){1'b0}}, cbit};
            end
            default: wr_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) rf_q[r] <= '0;
            flag_q <= 1'b1;
            cmp_q  <= 1'b0;
        end else begin
            if (exec && wr_en) rf_q[rd_i] <= res;
            if (exec && is_cmp) cmp_q <= cbit;
            if (setall_i) flag_q <= 1'b1;
            else if (exec && is_cmp && fupd_i) flag_q <= cbit;
        end
    end
endmodule

// File: rtl/simd_reduce.sv
module simd_reduce #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags_i,
    input  logic [N-1:0] cmp_i,
    input  logic         mask_i,
    output logic         any_o,
    output logic         all_o
);
    logic [N-1:0] eff_any, eff_all;
    logic         any_q, all_q;

    assign eff_any = cmp_i & (mask_i ? flags_i : {N{1'b1}});
    assign eff_all = cmp_i | (mask_i ? ~flags_i : {N{1'b0}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            any_q <= 1'b0;
            all_q <= 1'b0;
        end else begin
            any_q <= |eff_any;
            all_q <= &eff_all;
        end
    end

    assign any_o = any_q;
    assign all_o = all_q;
endmodule

// File: rtl/simd_seq.sv
module simd_seq
    import simd_pkg::*;
#(
    parameter int PC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [3:0]       op_i,
    input  logic [1:0]       brc_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             any_i,
    input  logic             all_i,
    output logic [PC_W-1:0]  pc_o,
    output seq_state_e       state_o,
    output logic             issue_o,
    output logic             setall_o,
    output logic             rdpe_o
);
    seq_state_e      state_q, state_d;
    logic [PC_W-1:0] pc_q, pc_d;
    logic            cond, taken;

    assign cond  = brc_i[0] ? all_i : any_i;
    assign taken = (cond == brc_i[1]);

    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        unique case (state_q)
            ST_IDLE, ST_HALT: begin
                if (start_i) begin
                    state_d = ST_RUN;
                    pc_d    = '0;
                end
            end
            ST_RUN: begin
                if (op_i == OP_HALT) begin
                    state_d = ST_HALT;
                end else if (op_i == OP_BR && taken) begin
                    pc_d = PC_W'(imm_i);
                end else begin
                    pc_d = pc_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                pc_d    = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
        end
    end

    always_comb begin
        issue_o  = (state_q == ST_RUN) && op_i[3];
        setall_o = (state_q == ST_RUN) && (op_i == OP_SETALL);
        rdpe_o   = (state_q == ST_RUN) && (op_i == OP_RDPE);
    end

    assign pc_o    = pc_q;
    assign state_o = state_q;
endmodule

// File: rtl/simd_array_ctl.sv
module simd_array_ctl
    import simd_pkg::*;
#(
    parameter int N    = 8,
    parameter int W    = 8,
    parameter int PC_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               red_mask_i,
    output logic [PC_W-1:0]    pc_o,
    output logic               busy_o,
    output logic               halted_o,
    output logic [W-1:0]       scalar_o,
    output logic [N-1:0]       flags_o,
    output logic               any_o,
    output logic               all_o
);
    localparam int SEL_W = (N > 1) ? $clog2(N) : 1;

    instr_t       ins;
    seq_state_e   state;
    logic         issue, setall, rdpe;
    logic [N-1:0] flags, cmps;
    logic [W-1:0] rdval [N];
    logic [W-1:0] scalar_q;

    assign ins = instr_t'(instr_i);

    simd_seq #(.PC_W(PC_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .op_i     (ins.op),
        .brc_i    (ins.rd),
        .imm_i    (ins.imm),
        .any_i    (any_o),
        .all_i    (all_o),
        .pc_o     (pc_o),
        .state_o  (state),
        .issue_o  (issue),
        .setall_o (setall),
        .rdpe_o   (rdpe)
    );

    for (genvar i = 0; i < N; i++) begin : g_lane
        simd_pe #(.W(W), .LANE(i)) u_pe (
            .clk      (clk),
            .rst_n    (rst_n),
            .issue_i  (issue),
            .op_i     (ins.op),
            .fupd_i   (ins.fupd),
            .rd_i     (ins.rd),
            .rs1_i    (ins.rs1),
            .rs2_i    (ins.rs2),
            .imm_i    (ins.imm),
            .setall_i (setall),
            .flag_o   (flags[i]),
            .cmp_o    (cmps[i]),
            .rdval_o  (rdval[i])
        );
    end

    simd_reduce #(.N(N)) u_red (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (flags),
        .cmp_i   (cmps),
        .mask_i  (red_mask_i),
        .any_o   (any_o),
        .all_o   (all_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scalar_q <= '0;
        else if (rdpe) scalar_q <= rdval[ins.imm[SEL_W-1:0]];
    end

    assign scalar_o = scalar_q;
    assign flags_o  = flags;
    assign busy_o   = (state == ST_RUN);
    assign halted_o = (state == ST_HALT);
endmodule

// File: rtl/simd_array_ctl_chk.sv
module simd_array_ctl_chk #(
    parameter int N    = 8,
    parameter int PC_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [3:0]      op_i,
    input logic [1:0]      brc_i,
    input logic [4:0]      imm_i,
    input logic            red_mask_i,
    input logic [PC_W-1:0] pc_o,
    input logic            busy_o,
    input logic            halted_o,
    input logic [N-1:0]    flags_o,
    input logic            any_o,
    input logic            all_o
);
    AST_IDLE_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> (pc_o == $past(pc_o))); // R11
    AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && pc_o == '0)); // R2
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && op_i != 4'd1 && op_i != 4'd2) |=> (pc_o == PC_W'($past(pc_o) + 1'b1))); // R2
    AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && op_i == 4'd2 && ((brc_i[0] ? all_o : any_o) == brc_i[1]))
        |=> (pc_o == PC_W'($past(imm_i)))); // R9
    AST_SETALL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && op_i == 4'd4) |=> (&flags_o)); // R6
    AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && op_i == 4'd1) |=> (halted_o && !busy_o)); // R11
    AST_ALL_IMPLIES_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(red_mask_i) && all_o) |-> any_o); // R7

    for (genvar i = 0; i < N; i++) begin : g_lane_chk
        AST_INACTIVE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
            (!flags_o[i] && !(busy_o && op_i == 4'd4)) |=> !flags_o[i]); // R4
    end
endmodule

bind simd_array_ctl simd_array_ctl_chk #(.N(N), .PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .op_i       (instr_i[15:12]),
    .brc_i      (instr_i[10:9]),
    .imm_i      (instr_i[4:0]),
    .red_mask_i (red_mask_i),
    .pc_o       (pc_o),
    .busy_o     (busy_o),
    .halted_o   (halted_o),
    .flags_o    (flags_o),
    .any_o      (any_o),
    .all_o      (all_o)
);

// File: tb/simd_array_ctl_bench.sv
module simd_array_ctl_bench;
    import simd_pkg::*;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int N = 8, W = 8, PC_W = 5, NROWS = 21;
    localparam logic [2:0] K_NONE = 0, K_PC = 1, K_SCAL = 2, K_FLAG = 3, K_AA = 4, K_HALT = 5;

    function automatic logic [15:0] mk(input logic [3:0] op, input logic f, input logic [1:0] rd,
                                       input logic [1:0] rs1, input logic [1:0] rs2, input logic [4:0] imm);
        return {op, f, rd, rs1, rs2, imm};
    endfunction

    function automatic logic [30:0] row(input logic [15:0] ins, input logic [2:0] kind,
                                        input logic [7:0] exp, input logic [3:0] req);
        return {ins, kind, exp, req};
    endfunction

    localparam logic [30:0] ROWS [NROWS] = '{
        row(mk(OP_LID, 0, 0, 0, 0, 0), K_PC, 8'd1, 4'd2),
        row(mk(OP_LDI, 0, 1, 0, 0, 3), K_PC, 8'd2, 4'd2),
        row(mk(OP_ADD, 0, 2, 0, 1, 0), K_NONE, 8'd0, 4'd3),
        row(mk(OP_RDPE, 0, 0, 2, 0, 5), K_SCAL, 8'd8, 4'd3),
        row(mk(OP_CLT, 1, 3, 0, 1, 0), K_FLAG, 8'h07, 4'd5),
        row(mk(OP_NOP, 0, 0, 0, 0, 0), K_AA, 8'b10, 4'd7),
        row(mk(OP_LDI, 0, 2, 0, 0, 9), K_NONE, 8'd0, 4'd4),
        row(mk(OP_RDPE, 0, 0, 2, 0, 7), K_SCAL, 8'd10, 4'd4),
        row(mk(OP_RDPE, 0, 0, 2, 0, 1), K_SCAL, 8'd9, 4'd3),
        row(mk(OP_RDPE, 0, 0, 3, 0, 2), K_SCAL, 8'd1, 4'd5),
        row(mk(OP_CEQ, 1, 3, 0, 1, 0), K_FLAG, 8'h00, 4'd5),
        row(mk(OP_ADD, 0, 1, 1, 1, 0), K_NONE, 8'd0, 4'd4),
        row(mk(OP_NOP, 0, 0, 0, 0, 0), K_AA, 8'b00, 4'd7),
        row(mk(OP_SETALL, 0, 0, 0, 0, 0), K_FLAG, 8'hFF, 4'd6),
        row(mk(OP_RDPE, 0, 0, 1, 0, 0), K_SCAL, 8'd3, 4'd4),
        row(mk(OP_CLT, 0, 3, 1, 0, 0), K_FLAG, 8'hFF, 4'd5),
        row(mk(OP_NOP, 0, 0, 0, 0, 0), K_AA, 8'b10, 4'd7),
        row(mk(OP_BR, 0, 2'b10, 0, 0, 20), K_PC, 8'd20, 4'd9),
        row(mk(OP_BR, 0, 2'b11, 0, 0, 3), K_PC, 8'd21, 4'd9),
        row(mk(OP_BR, 0, 2'b01, 0, 0, 2), K_PC, 8'd2, 4'd9),
        row(mk(OP_HALT, 0, 0, 0, 0, 0), K_HALT, 8'd1, 4'd11)
    };

    logic            clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, red_mask_i = 1'b0;
    logic [15:0]     instr_i = '0;
    logic [PC_W-1:0] pc_o;
    logic            busy_o, halted_o, any_o, all_o;
    logic [W-1:0]    scalar_o;
    logic [N-1:0]    flags_o;
    int              n_chk = 0, n_fail = 0, cyc = 0;

    always #2.5 clk = ~clk;

    simd_array_ctl #(.N(N), .W(W), .PC_W(PC_W)) u_simd_array_ctl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i), .red_mask_i(red_mask_i),
        .pc_o(pc_o), .busy_o(busy_o), .halted_o(halted_o), .scalar_o(scalar_o),
        .flags_o(flags_o), .any_o(any_o), .all_o(all_o)
    );

    function automatic string rname(input logic [3:0] r);
        case (r)
            4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
            4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
            4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
            4'd10: return "R10"; 4'd11: return "R11"; default: return "R?";
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic step(input logic [15:0] ins);
        instr_i = ins;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1", pc_o, 0);
        chk("R1", {busy_o, halted_o}, 0);
        chk("R1", flags_o, 8'hFF);
        chk("R1", scalar_o, 0);
        chk("R1", {any_o, all_o}, 0);

        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2", {busy_o, 3'b0, pc_o}, {1'b1, 8'd0});

        for (int i = 0; i < NROWS; i++) begin
            logic [15:0] ins;
            logic [2:0]  kind;
            logic [7:0]  exp;
            logic [3:0]  req;
            {ins, kind, exp, req} = ROWS[i];
            step(ins);
            case (kind)
                K_PC:    chk(rname(req), pc_o, exp);
                K_SCAL:  chk(rname(req), scalar_o, exp);
                K_FLAG:  chk(rname(req), flags_o, exp);
                K_AA:    chk(rname(req), {any_o, all_o}, exp);
                K_HALT:  chk(rname(req), halted_o, exp);
                default: ;
            endcase
        end

        // R11: instructions ignored while halted, pc holds
        step(mk(OP_LDI, 0, 1, 0, 0, 7));
        chk("R11", pc_o, 2);
        chk("R11", halted_o, 1);
        start_i = 1'b1;
        step(mk(OP_NOP, 0, 0, 0, 0, 0));
        start_i = 1'b0;
        chk("R11", {busy_o, 3'b0, pc_o}, {1'b1, 8'd0});
        step(mk(OP_RDPE, 0, 0, 1, 0, 0));
        chk("R11", scalar_o, 3);

        // R8: reduction masked to active lanes
        red_mask_i = 1'b1;
        step(mk(OP_CLT, 1, 3, 1, 0, 0));
        chk("R5", flags_o, 8'hF0);
        step(mk(OP_NOP, 0, 0, 0, 0, 0));
        chk("R8", {any_o, all_o}, 2'b11);
        step(mk(OP_CEQ, 1, 3, 0, 1, 0));
        chk("R5", flags_o, 8'h00);
        step(mk(OP_NOP, 0, 0, 0, 0, 0));
        chk("R8", {any_o, all_o}, 2'b01);
        step(mk(OP_BR, 0, 2'b11, 0, 0, 9));
        chk("R9", pc_o, 9);
        red_mask_i = 1'b0;
        step(mk(OP_NOP, 0, 0, 0, 0, 0));
        chk("R7", {any_o, all_o}, 2'b00);
        step(mk(OP_HALT, 0, 0, 0, 0, 0));
        chk("R11", halted_o, 1);

        finish_run();
    end
endmodule